// File: doc/BRIEF.md
# Exception entry control unit

This block performs the privileged-state side of taking a fault, interrupt or reset on a simple 32-bit RISC core. The pipeline presents a one-cycle take strobe with the kind of event, the PC of the faulting instruction and the PC that would have followed it, and the present contents of four control registers: status, cause, exception PC and shadow-set control. One clock later the block returns the new values for those four registers, a one-cycle redirect strobe and the handler address the fetch unit must jump to.

For ordinary faults and interrupts, entry raises the exception-level bit, records whether the instruction sat in a branch delay slot, loads the return address and the cause code, and rotates the shadow register set fields if the core was running normally. A reset sets the floating-point coprocessor usable bit and jumps to the reset vector. Soft reset and the non-maskable interrupt are accepted but only jump to the reset vector. Flushing, translation, interrupt prioritisation and exception return belong to other blocks.

Top module: `exc_entry_ctl`

## Requirements
- R1: After reset all outputs are zero. `redirect_o` is high in exactly the cycle after a cycle with `take_i` high, and low in every other cycle.
- R2: Kind codes on `kind_i`: 0 syscall, 1 reserved instruction, 2 overflow, 3 trap, 4 breakpoint, 5 machine check, 6 coprocessor unusable, 7 address error, 8 TLB invalid, 9 TLB refill, 10 TLB modified, 15 spare. These are ordinary faults. Their handler is 0x80000180 when status bit 22 (boot vectors) is 0, and 0xBFC00380 when that bit is 1.
- R3: Kind 11 (interrupt) jumps to 0x80000000 when status bit 22 is 0, and to 0xBFC00200 when it is 1.
- R4: Kinds 12 (reset), 13 (soft reset) and 14 (NMI) jump to 0xBFC00000, whatever the status value.
- R5: On an ordinary fault or an interrupt, status bit 1 (exception level) becomes 1 even if it was already 1. All other status bits are copied unchanged.
- R6: On an ordinary fault or an interrupt with status bits 1 and 22 both 0, the shadow control output takes the input with bits [9:6] replaced by input bits [3:0] and bits [3:0] replaced by input bits [15:12]. In every other case the shadow control output equals its input.
- R7: On an ordinary fault or an interrupt, the instruction is in a delay slot when `npc_i` differs from `pc_i`+4. Cause bit 31 then becomes 1 and the exception PC becomes `pc_i`-4. Otherwise cause bit 31 becomes 0 and the exception PC becomes `pc_i`.
- R8: On an ordinary fault or an interrupt, cause bits [29:28] are cleared and cause bits [6:2] take the event code, with all other cause bits kept. The codes are: interrupt 0, TLB modified 1, syscall 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, machine check 24. Address error, TLB invalid, TLB refill and spare use 31.
- R9: On a reset, status bit 29 is set and all other status bits are kept; exception level is not forced. Cause, exception PC and shadow control are passed through unchanged.
- R10: On a soft reset or an NMI, all four register outputs equal their inputs.
- R11: In a cycle after one without `take_i`, the four register outputs and `handler_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| take_i | input | 1 | One-cycle strobe: take the event now |
| kind_i | input | 4 | Event kind code (R2 to R4) |
| pc_i | input | 32 | PC of the interrupted instruction |
| npc_i | input | 32 | PC that would have followed it |
| status_i | input | 32 | Present status register |
| cause_i | input | 32 | Present cause register |
| epc_i | input | 32 | Present exception PC register |
| srs_i | input | 32 | Present shadow-set control register |
| status_o | output | 32 | New status value |
| cause_o | output | 32 | New cause value |
| epc_o | output | 32 | New exception PC value |
| srs_o | output | 32 | New shadow-set control value |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| handler_o | output | 32 | Address to redirect fetch to |

## Verification
The bench uses random register contents and random kinds. With these, roughly a quarter of the ordinary entries have both exception level and boot-vector clear, so rotated and unrotated shadow fields both occur often. Next-PC values are half sequential and half arbitrary, which separates the delay-slot return address from the plain one. Directed cases cover two groups. The first is entry with exception level already set, and with boot vectors selected, to tell the two vector bases and the rotation guard apart. The second is each of the reset, soft-reset and NMI kinds, to confirm that only reset touches a status bit. Idle cycles between takes show that the outputs hold.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef enum logic [3:0] {
      K_SYSCALL = 4'd0,  K_RSVD   = 4'd1,  K_OVFL  = 4'd2,  K_TRAP   = 4'd3,
      K_BRK     = 4'd4,  K_MCHK   = 4'd5,  K_COPU  = 4'd6,  K_ADDR   = 4'd7,
      K_TLBI    = 4'd8,  K_TLBR   = 4'd9,  K_TLBM  = 4'd10, K_IRQ    = 4'd11,
      K_RESET   = 4'd12, K_SRESET = 4'd13, K_NMI   = 4'd14, K_SPARE  = 4'd15
   } exc_kind_e;

   typedef enum logic [1:0] {
      CLS_FAULT = 2'd0,
      CLS_INT   = 2'd1,
      CLS_RESET = 2'd2,
      CLS_QUIET = 2'd3
   } exc_cls_e;

   localparam int XLEN     = 32;
   localparam int CODE_W   = 5;
   // status fields
   localparam int ST_EXL   = 1;
   localparam int ST_BEV   = 22;
   localparam int ST_CU1   = 29;
   // cause fields
   localparam int CA_BD    = 31;
   localparam int CA_CE_LO = 28;
   localparam int CA_CE_W  = 2;
   localparam int CA_EC_LO = 2;
   // shadow-set control fields
   localparam int SS_W     = 4;
   localparam int SS_CUR   = 0;
   localparam int SS_PREV  = 6;
   localparam int SS_EXC   = 12;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
   import exc_pkg::*;
#(
   parameter int unsigned DUMMY_CODE = 31
) (
   input  exc_kind_e           kind_i,
   output exc_cls_e            cls_o,
   output logic [CODE_W-1:0]   code_o
);

   if (DUMMY_CODE >= (1 << CODE_W)) begin : g_bad_dummy
      $error("DUMMY_CODE does not fit the cause code field");
   end

   localparam logic [CODE_W-1:0] DUMMY = CODE_W'(DUMMY_CODE);

   always_comb begin
      cls_o  = CLS_FAULT;
      code_o = DUMMY;
      unique case (kind_i)
         K_SYSCALL: code_o = 5'd8;
         K_RSVD:    code_o = 5'd10;
         K_OVFL:    code_o = 5'd12;
         K_TRAP:    code_o = 5'd13;
         K_BRK:     code_o = 5'd9;
         K_MCHK:    code_o = 5'd24;
         K_COPU:    code_o = 5'd11;
         K_TLBM:    code_o = 5'd1;
         K_ADDR, K_TLBI, K_TLBR, K_SPARE: code_o = DUMMY;
         K_IRQ: begin
            cls_o  = CLS_INT;
            code_o = 5'd0;
         end
         K_RESET:        cls_o = CLS_RESET;
         K_SRESET, K_NMI: cls_o = CLS_QUIET;
         default: ;
      endcase
   end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
   import exc_pkg::*;
#(
   parameter logic [XLEN-1:0] RESET_VEC  = 32'hBFC0_0000,
   parameter logic [XLEN-1:0] RUN_BASE   = 32'h8000_0000,
   parameter logic [XLEN-1:0] BOOT_BASE  = 32'hBFC0_0200,
   parameter logic [XLEN-1:0] FAULT_OFS  = 32'h0000_0180,
   parameter logic [XLEN-1:0] INT_OFS    = 32'h0000_0000
) (
   input  exc_cls_e          cls_i,
   input  logic              bev_i,
   output logic [XLEN-1:0]   vec_o
);

   if (RESET_VEC[1:0] != 2'b00 || RUN_BASE[1:0] != 2'b00 || BOOT_BASE[1:0] != 2'b00)
   begin : g_bad_align
      $error("vector bases must be word aligned");
   end
   if (FAULT_OFS >= 32'h200 || INT_OFS >= 32'h200) begin : g_bad_ofs
      $error("vector offsets must stay below 0x200");
   end

   logic [XLEN-1:0] base;

   always_comb begin
      base = bev_i ? BOOT_BASE : RUN_BASE;
      unique case (cls_i)
         CLS_FAULT: vec_o = base + FAULT_OFS;
         CLS_INT:   vec_o = base + INT_OFS;
         default:   vec_o = RESET_VEC;
      endcase
   end

endmodule

// File: rtl/exc_state_next.sv
module exc_state_next
   import exc_pkg::*;
#(
   parameter int unsigned INSN_BYTES = 4,
   parameter bit          SRS_EN     = 1'b1
) (
   input  exc_cls_e            cls_i,
   input  logic [CODE_W-1:0]   code_i,
   input  logic [XLEN-1:0]     pc_i,
   input  logic [XLEN-1:0]     npc_i,
   input  logic [XLEN-1:0]     status_i,
   input  logic [XLEN-1:0]     cause_i,
   input  logic [XLEN-1:0]     epc_i,
   input  logic [XLEN-1:0]     srs_i,
   output logic [XLEN-1:0]     status_o,
   output logic [XLEN-1:0]     cause_o,
   output logic [XLEN-1:0]     epc_o,
   output logic [XLEN-1:0]     srs_o
);

   if (INSN_BYTES == 0 || INSN_BYTES > 8) begin : g_bad_step
      $error("INSN_BYTES out of range");
   end

   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   logic [XLEN-1:0] srs_rot;
   logic            in_slot;
   logic            may_rot;

   if (SRS_EN) begin : g_rot
      always_comb begin
         srs_rot                    = srs_i;
         srs_rot[SS_PREV +: SS_W]   = srs_i[SS_CUR +: SS_W];
         srs_rot[SS_CUR +: SS_W]    = srs_i[SS_EXC +: SS_W];
      end
   end else begin : g_no_rot
      assign srs_rot = srs_i;
   end

   assign in_slot = (npc_i != pc_i + STEP);
   assign may_rot = !status_i[ST_EXL] && !status_i[ST_BEV];

   always_comb begin
      status_o = status_i;
      cause_o  = cause_i;
      epc_o    = epc_i;
      srs_o    = srs_i;
      unique case (cls_i)
         CLS_FAULT, CLS_INT: begin
            status_o[ST_EXL]                   = 1'b1;
            epc_o                              = in_slot ? pc_i - STEP : pc_i;
            cause_o[CA_BD]                     = in_slot;
            cause_o[CA_CE_LO +: CA_CE_W]       = '0;
            cause_o[CA_EC_LO +: CODE_W]        = code_i;
            if (may_rot) srs_o = srs_rot;
         end
         CLS_RESET: status_o[ST_CU1] = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl
   import exc_pkg::*;
#(
   parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000,
   parameter logic [31:0] RUN_BASE   = 32'h8000_0000,
   parameter logic [31:0] BOOT_BASE  = 32'hBFC0_0200,
   parameter logic [31:0] FAULT_OFS  = 32'h0000_0180,
   parameter logic [31:0] INT_OFS    = 32'h0000_0000,
   parameter int unsigned INSN_BYTES = 4,
   parameter int unsigned DUMMY_CODE = 31,
   parameter bit          SRS_EN     = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        take_i,
   input  logic [3:0]  kind_i,
   input  logic [31:0] pc_i,
   input  logic [31:0] npc_i,
   input  logic [31:0] status_i,
   input  logic [31:0] cause_i,
   input  logic [31:0] epc_i,
   input  logic [31:0] srs_i,
   output logic [31:0] status_o,
   output logic [31:0] cause_o,
   output logic [31:0] epc_o,
   output logic [31:0] srs_o,
   output logic        redirect_o,
   output logic [31:0] handler_o
);

   exc_cls_e           cls;
   logic [CODE_W-1:0]  code;
   logic [XLEN-1:0]    vec_n, st_n, ca_n, ep_n, sr_n;

   exc_classify #(.DUMMY_CODE(DUMMY_CODE)) u_cls (
      .kind_i (exc_kind_e'(kind_i)),
      .cls_o  (cls),
      .code_o (code)
   );

   exc_vector_gen #(
      .RESET_VEC (RESET_VEC), .RUN_BASE (RUN_BASE), .BOOT_BASE (BOOT_BASE),
      .FAULT_OFS (FAULT_OFS), .INT_OFS  (INT_OFS)
   ) u_vec (
      .cls_i (cls),
      .bev_i (status_i[ST_BEV]),
      .vec_o (vec_n)
   );

   exc_state_next #(.INSN_BYTES(INSN_BYTES), .SRS_EN(SRS_EN)) u_nxt (
      .cls_i    (cls),
      .code_i   (code),
      .pc_i     (pc_i),
      .npc_i    (npc_i),
      .status_i (status_i),
      .cause_i  (cause_i),
      .epc_i    (epc_i),
      .srs_i    (srs_i),
      .status_o (st_n),
      .cause_o  (ca_n),
      .epc_o    (ep_n),
      .srs_o    (sr_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect_o <= 1'b0;
         handler_o  <= '0;
         status_o   <= '0;
         cause_o    <= '0;
         epc_o      <= '0;
         srs_o      <= '0;
      end else begin
         redirect_o <= take_i;
         if (take_i) begin
            handler_o <= vec_n;
            status_o  <= st_n;
            cause_o   <= ca_n;
            epc_o     <= ep_n;
            srs_o     <= sr_n;
         end
      end
   end

   logic entry_norm;
   assign entry_norm = (cls == CLS_FAULT) || (cls == CLS_INT);

   // R1
   redirect_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> redirect_o);

   // R1
   no_spurious_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> !redirect_o);

   // R4
   reset_group_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && kind_i >= 4'd12 && kind_i <= 4'd14) |=> handler_o == RESET_VEC);

   // R5
   exl_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && entry_norm) |=> status_o[ST_EXL]);

   // R7
   slot_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && entry_norm && npc_i != pc_i + 32'(INSN_BYTES))
      |=> (cause_o[CA_BD] && epc_o == $past(pc_i) - 32'(INSN_BYTES)));

   // R10
   quiet_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && cls == CLS_QUIET) |=> (status_o == $past(status_i) && srs_o == $past(srs_i)));

   // R11
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> ($stable(status_o) && $stable(cause_o) && $stable(epc_o)
                   && $stable(srs_o) && $stable(handler_o)));

   if (SRS_EN) begin : g_srs_chk
      // R6
      srs_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (take_i && entry_norm && !status_i[ST_EXL] && !status_i[ST_BEV])
         |=> srs_o[SS_PREV +: SS_W] == $past(srs_i[SS_CUR +: SS_W]));
   end

endmodule

// File: tb/exc_entry_ctl_tb.sv
module exc_entry_ctl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        take_i = 1'b0;
   logic [3:0]  kind_i = '0;
   logic [31:0] pc_i = '0, npc_i = '0, status_i = '0, cause_i = '0, epc_i = '0, srs_i = '0;
   logic [31:0] status_o, cause_o, epc_o, srs_o, handler_o;
   logic        redirect_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   exc_entry_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .take_i(take_i), .kind_i(kind_i),
      .pc_i(pc_i), .npc_i(npc_i), .status_i(status_i), .cause_i(cause_i),
      .epc_i(epc_i), .srs_i(srs_i), .status_o(status_o), .cause_o(cause_o),
      .epc_o(epc_o), .srs_o(srs_o), .redirect_o(redirect_o), .handler_o(handler_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
      end
   endtask

   function automatic bit is_norm(input logic [3:0] k);
      return (k <= 4'd11) || (k == 4'd15);
   endfunction

   function automatic logic [31:0] m_vec(input logic [3:0] k, input logic [31:0] st);
      logic [31:0] b;
      b = st[22] ? 32'hBFC0_0200 : 32'h8000_0000;
      if (k >= 4'd12 && k <= 4'd14) return 32'hBFC0_0000;
      if (k == 4'd11) return b;
      return b + 32'h180;
   endfunction

   function automatic logic [4:0] m_code(input logic [3:0] k);
      case (k)
         4'd0: return 5'd8;   4'd1: return 5'd10;  4'd2: return 5'd12;
         4'd3: return 5'd13;  4'd4: return 5'd9;   4'd5: return 5'd24;
         4'd6: return 5'd11;  4'd10: return 5'd1;  4'd11: return 5'd0;
         default: return 5'd31;
      endcase
   endfunction

   // One take followed by an idle cycle; checks every output against the model.
   task automatic take(input logic [3:0] k, input logic [31:0] pc, input logic [31:0] npc,
                       input logic [31:0] st, input logic [31:0] ca,
                       input logic [31:0] ep, input logic [31:0] sr);
      logic [31:0] e_st, e_ca, e_ep, e_sr;
      bit slot;
      e_st = st; e_ca = ca; e_ep = ep; e_sr = sr;
      slot = (npc != pc + 32'd4);
      if (is_norm(k)) begin
         e_st[1] = 1'b1;
         e_ep = slot ? pc - 32'd4 : pc;
         e_ca[31] = slot;
         e_ca[29:28] = 2'b00;
         e_ca[6:2] = m_code(k);
         if (!st[1] && !st[22]) begin
            e_sr[9:6] = sr[3:0];
            e_sr[3:0] = sr[15:12];
         end
      end else if (k == 4'd12) begin
         e_st[29] = 1'b1;
      end
      @(negedge clk);
      take_i = 1'b1; kind_i = k; pc_i = pc; npc_i = npc;
      status_i = st; cause_i = ca; epc_i = ep; srs_i = sr;
      @(negedge clk);
      take_i = 1'b0;
      status_i = $urandom; cause_i = $urandom; kind_i = 4'($urandom);
      check("R1", "redirect", {31'd0, redirect_o}, 32'd1);
      if (k == 4'd11)
         check("R3", "irq handler", handler_o, m_vec(k, st));
      else if (k >= 4'd12 && k <= 4'd14)
         check("R4", "reset handler", handler_o, m_vec(k, st));
      else
         check("R2", "fault handler", handler_o, m_vec(k, st));
      if (k == 4'd12) check("R9", "status", status_o, e_st);
      else if (k == 4'd13 || k == 4'd14) check("R10", "status", status_o, e_st);
      else check("R5", "status", status_o, e_st);
      if (is_norm(k)) begin
         check("R6", "srs", srs_o, e_sr);
         check("R7", "epc", epc_o, e_ep);
         check("R8", "cause", cause_o, e_ca);
      end else begin
         check("R10", "srs", srs_o, e_sr);
         check("R10", "epc", epc_o, e_ep);
         check("R10", "cause", cause_o, e_ca);
      end
      @(negedge clk);
      check("R1", "redirect low", {31'd0, redirect_o}, 32'd0);
      check("R11", "status hold", status_o, e_st);
      check("R11", "handler hold", handler_o, m_vec(k, st));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0000_5EED));
      repeat (3) @(negedge clk);
      check("R1", "reset redirect", {31'd0, redirect_o}, 32'd0);
      check("R1", "reset status", status_o, 32'd0);
      check("R1", "reset handler", handler_o, 32'd0);
      rst_n = 1'b1;
      // directed corners
      take(4'd0,  32'h0000_1000, 32'h0000_1004, 32'h0000_0000, 32'h3000_0000, 32'h0, 32'h0000_A003); // R6 rotate, R7 no slot
      take(4'd3,  32'h0000_2000, 32'h0000_3000, 32'h0000_0002, 32'hFFFF_FFFF, 32'h0, 32'h0000_5003); // R6 exl set, R7 slot
      take(4'd5,  32'h0000_2000, 32'h0000_2004, 32'h0040_0000, 32'h0, 32'h0, 32'h0000_7001);         // R2 boot base
      take(4'd11, 32'h0000_4000, 32'h0000_4004, 32'h0000_0000, 32'h0, 32'h0, 32'h0);                 // R3 run
      take(4'd11, 32'h0000_4000, 32'h0000_4004, 32'h0040_0000, 32'h0, 32'h0, 32'h0);                 // R3 boot
      take(4'd12, 32'h0000_4000, 32'h0000_5000, 32'h0000_0000, 32'h1234_5678, 32'h55, 32'hF0F0);     // R9
      take(4'd13, 32'h0000_4000, 32'h0000_5000, 32'h0040_0002, 32'h1, 32'h2, 32'h3);                 // R10
      take(4'd14, 32'h0000_4000, 32'h0000_5000, 32'hFFFF_FFFF, 32'h1, 32'h2, 32'h3);                 // R10
      take(4'd7,  32'h0000_0004, 32'h0000_0000, 32'h0000_0000, 32'h0, 32'h0, 32'h0);                 // R8 dummy
      take(4'd15, 32'hFFFF_FFFC, 32'h0000_0000, 32'h0000_0000, 32'h0, 32'h0, 32'h0);                 // R7 wrap
      // random
      for (int i = 0; i < 400; i++) begin
         logic [31:0] pc;
         pc = $urandom & 32'hFFFF_FFFC;
         take(4'($urandom), pc, ($urandom & 1) ? pc + 32'd4 : ($urandom & 32'hFFFF_FFFC),
              $urandom, $urandom, $urandom, $urandom);
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule